// File: doc/BRIEF.md
# Host Register File for a 16550-Compatible Serial Port

This block is the byte-wide, eight-offset register window that a processor sees when it drives a 16550-style serial port. It decodes host reads and writes and keeps the control state: line format, modem control, interrupt enables, FIFO control, scratch and the 16-bit baud divisor. It feeds that state to the baud generator, the FIFOs and the modem pins. Status flows back as live levels and one-cycle error events. The block latches those into the line and modem status bytes, and reading a status byte clears the latched part.

Three quirks shape the decoding. Line control bit 7 turns offsets 0 and 1 into the low and high divisor bytes. Offset 2 is write-only FIFO control but reads back as an identification byte. The 64-entry FIFO mode bit is accepted only when it is written while the divisor bit is set. The interrupt code in the low identification nibble comes from a separate interrupt-priority unit as an input.

Top module: `uart_regfile`

## Requirements
- R1: After reset the divisor, line control, modem control and interrupt enable are all zero, and offset 2 reads as {4'b0000, int_code}.
- R2: With line control bit 7 clear, a write to offset 0 pulses tx_push for that cycle with tx_data equal to the written byte. A read of offset 0 returns rx_data and pulses rx_pop. Offset 1 holds a 4-bit interrupt enable whose upper four bits read zero.
- R3: With line control bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes, div_value = {high, low}, and neither tx_push nor rx_pop pulses.
- R4: A write to offset 2 sets fifo_en from bit 0, dma_mode from bit 3 and rx_trig from bits 7:6. A read of offset 2 returns the identification byte and never the written value.
- R5: Writing 1 to offset 2 bit 1 (bit 2) raises rx_fifo_clr (tx_fifo_clr) for exactly the one cycle after the write.
- R6: Offset 2 bit 5 updates the extended-FIFO state only when written while line control bit 7 is set. Otherwise the previous state is kept.
- R7: The identification byte is {fifo_en, fifo_en, fifo_en & extended, 1'b0, int_code[3:0]}.
- R8: Line control reads back all 8 bits. Bits 1:0 give word_len, bit 2 stop2, bit 3 par_en, bit 4 par_even, bit 5 par_stick and bit 6 brk_force.
- R9: Modem control bits 0..5 drive dtr, rts, out1, out2, loopback and auto_flow. Its bits 7:6 read zero.
- R10: Line status is {rx_fifo_err, tx_idle, thr_empty, brk, framing, parity, overrun, rx_ready}. Bits 4:1 latch their event inputs and clear when offset 5 is read, and an event in the reading cycle stays latched.
- R11: Modem status is {dcd, ri, dsr, cts, ddcd, teri, ddsr, dcts} with the pins sampled by one register. A delta bit sets on any change of its pin, but teri sets only on a 1-to-0 change of ri. Reading offset 6 clears the deltas.
- R12: Offset 7 is an 8-bit scratch byte that reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tx_push | output | 1 | Transmit byte push pulse |
| tx_data | output | 8 | Transmit byte |
| rx_pop | output | 1 | Receive byte pop pulse |
| rx_data | input | 8 | Head of receive path |
| int_code | input | 4 | Pending interrupt code |
| div_value | output | 16 | Baud divisor |
| word_len | output | 2 | Data bits minus 5 |
| stop2 | output | 1 | Two stop bits |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity |
| par_stick | output | 1 | Stick parity |
| brk_force | output | 1 | Force break |
| irq_en | output | 4 | Interrupt enables |
| dtr | output | 1 | DTR pin |
| rts | output | 1 | RTS pin |
| out1 | output | 1 | General output 1 |
| out2 | output | 1 | General output 2 |
| loopback | output | 1 | Loopback mode |
| auto_flow | output | 1 | Automatic flow control |
| fifo_en | output | 1 | FIFO enable |
| fifo_ext | output | 1 | 64-entry FIFO mode active |
| dma_mode | output | 1 | DMA mode select |
| rx_trig | output | 2 | Receive trigger level |
| rx_fifo_clr | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO clear pulse |
| rx_ready | input | 1 | Receive data available |
| ev_overrun | input | 1 | Overrun event |
| ev_parity | input | 1 | Parity error event |
| ev_framing | input | 1 | Framing error event |
| ev_break | input | 1 | Break event |
| thr_empty | input | 1 | Transmit holding empty |
| tx_idle | input | 1 | Transmitter fully empty |
| rx_fifo_err | input | 1 | Error somewhere in receive FIFO |
| cts | input | 1 | Clear to send pin |
| dsr | input | 1 | Data set ready pin |
| ri | input | 1 | Ring indicator pin |
| dcd | input | 1 | Carrier detect pin |

## Verification
The bench builds the block with its default 16-bit divisor. At that width, distinct high and low bytes such as 0x1234 show any byte swap or truncation when the divisor bit is set. The defaults also allow the extended-FIFO bit to be written with the divisor bit set and then with it clear. The identification byte can therefore be seen moving between 0x01, 0xC1 and 0xE1, which covers each FIFO depth a driver would infer.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OFS_BUF  = 3'd0,
    OFS_IEN  = 3'd1,
    OFS_IDF  = 3'd2,
    OFS_LCTL = 3'd3,
    OFS_MCTL = 3'd4,
    OFS_LSTS = 3'd5,
    OFS_MSTS = 3'd6,
    OFS_SCR  = 3'd7
  } ofs_e;

  // identification byte: FIFO state on top, interrupt code below
  function automatic logic [7:0] ident_byte(logic fen, logic ext, logic [3:0] code);
    return {fen, fen, fen & ext, 1'b0, code};
  endfunction

  // pin order {dcd, ri, dsr, cts}; result {ddcd, teri, ddsr, dcts}
  function automatic logic [3:0] modem_deltas(logic [3:0] prev, logic [3:0] now);
    return {prev[3] ^ now[3], prev[2] & ~now[2], prev[1] ^ now[1], prev[0] ^ now[0]};
  endfunction
endpackage

// File: rtl/ureg_fifo_ctl.sv
module ureg_fifo_ctl
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              dlab,
  input  logic [BYTE_W-1:0] wdata,
  output logic              fifo_en,
  output logic              ext_q,
  output logic              dma_mode,
  output logic [1:0]        rx_trig,
  output logic              rx_clr,
  output logic              tx_clr
);
  logic unused_rsvd;
  assign unused_rsvd = wdata[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      ext_q    <= 1'b0;
      dma_mode <= 1'b0;
      rx_trig  <= 2'b00;
      rx_clr   <= 1'b0;
      tx_clr   <= 1'b0;
    end else begin
      rx_clr <= we & wdata[1];
      tx_clr <= we & wdata[2];
      if (we) begin
        fifo_en  <= wdata[0];
        dma_mode <= wdata[3];
        rx_trig  <= wdata[7:6];
        if (dlab) ext_q <= wdata[5];
      end
    end
  end

  AST_RX_CLR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |-> $past(we) && $past(wdata[1])); // R5
  AST_TX_CLR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |-> $past(we) && $past(wdata[2])); // R5
  AST_EXT_NEEDS_DLAB: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q != $past(ext_q)) |-> $past(we) && $past(dlab)); // R6
endmodule

// File: rtl/ureg_line_sts.sv
module ureg_line_sts
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_clr,
  input  logic [3:0]        ev,      // {break, framing, parity, overrun}
  input  logic              rx_ready,
  input  logic              thr_empty,
  input  logic              tx_idle,
  input  logic              rx_fifo_err,
  output logic [BYTE_W-1:0] lsr
);
  logic [3:0] sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 4'b0;
    else        sticky_q <= (rd_clr ? 4'b0 : sticky_q) | ev;
  end

  assign lsr = {rx_fifo_err, tx_idle, thr_empty, sticky_q, rx_ready};

  AST_LSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_clr) && ($past(ev) == 4'b0) |-> lsr[4:1] == 4'b0); // R10
  AST_LSR_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev[0]) |-> lsr[1]); // R10
endmodule

// File: rtl/ureg_modem_sts.sv
module ureg_modem_sts
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_clr,
  input  logic [3:0]        pins,    // {dcd, ri, dsr, cts}
  output logic [BYTE_W-1:0] msr
);
  logic [3:0] pins_q;
  logic [3:0] delta_q;
  logic [3:0] delta_now;

  assign delta_now = modem_deltas(pins_q, pins);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q  <= 4'b0;
      delta_q <= 4'b0;
    end else begin
      pins_q  <= pins;
      delta_q <= (rd_clr ? 4'b0 : delta_q) | delta_now;
    end
  end

  assign msr = {pins_q, delta_q};

  AST_MSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_clr) && $stable(pins_q) |-> msr[3:0] == 4'b0); // R11
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_reg_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int IEN_W = 4,
  parameter int MCR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_data,
  output logic              rx_pop,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [3:0]        int_code,
  output logic [DIV_W-1:0]  div_value,
  output logic [1:0]        word_len,
  output logic              stop2,
  output logic              par_en,
  output logic              par_even,
  output logic              par_stick,
  output logic              brk_force,
  output logic [IEN_W-1:0]  irq_en,
  output logic              dtr,
  output logic              rts,
  output logic              out1,
  output logic              out2,
  output logic              loopback,
  output logic              auto_flow,
  output logic              fifo_en,
  output logic              fifo_ext,
  output logic              dma_mode,
  output logic [1:0]        rx_trig,
  output logic              rx_fifo_clr,
  output logic              tx_fifo_clr,
  input  logic              rx_ready,
  input  logic              ev_overrun,
  input  logic              ev_parity,
  input  logic              ev_framing,
  input  logic              ev_break,
  input  logic              thr_empty,
  input  logic              tx_idle,
  input  logic              rx_fifo_err,
  input  logic              cts,
  input  logic              dsr,
  input  logic              ri,
  input  logic              dcd
);
  localparam int HI_W = DIV_W - BYTE_W;

  ofs_e               ofs;
  logic [BYTE_W-1:0]  lcr_q, scr_q, div_lo_q;
  logic [HI_W-1:0]    div_hi_q;
  logic [IEN_W-1:0]   ien_q;
  logic [MCR_W-1:0]   mcr_q;
  logic               dlab, ext_q;
  logic [BYTE_W-1:0]  lsr_byte, msr_byte;

  // named decode events
  logic wr_lcr, wr_mcr, wr_scr, wr_fcr, wr_ien, wr_dll, wr_dlm;
  logic rd_lsr, rd_msr;

  assign ofs    = ofs_e'(bus_addr);
  assign dlab   = lcr_q[7];
  assign wr_lcr = bus_wr && ofs == OFS_LCTL;
  assign wr_mcr = bus_wr && ofs == OFS_MCTL;
  assign wr_scr = bus_wr && ofs == OFS_SCR;
  assign wr_fcr = bus_wr && ofs == OFS_IDF;
  assign wr_ien = bus_wr && ofs == OFS_IEN && !dlab;
  assign wr_dll = bus_wr && ofs == OFS_BUF && dlab;
  assign wr_dlm = bus_wr && ofs == OFS_IEN && dlab;
  assign rd_lsr = bus_rd && ofs == OFS_LSTS;
  assign rd_msr = bus_rd && ofs == OFS_MSTS;

  assign tx_push = bus_wr && ofs == OFS_BUF && !dlab;
  assign tx_data = bus_wdata;
  assign rx_pop  = bus_rd && ofs == OFS_BUF && !dlab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q    <= '0;
      scr_q    <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
      ien_q    <= '0;
      mcr_q    <= '0;
    end else begin
      if (wr_lcr) lcr_q    <= bus_wdata;
      if (wr_scr) scr_q    <= bus_wdata;
      if (wr_dll) div_lo_q <= bus_wdata;
      if (wr_dlm) div_hi_q <= bus_wdata[HI_W-1:0];
      if (wr_ien) ien_q    <= bus_wdata[IEN_W-1:0];
      if (wr_mcr) mcr_q    <= bus_wdata[MCR_W-1:0];
    end
  end

  ureg_fifo_ctl u_fifo (
    .clk(clk), .rst_n(rst_n), .we(wr_fcr), .dlab(dlab), .wdata(bus_wdata),
    .fifo_en(fifo_en), .ext_q(ext_q), .dma_mode(dma_mode), .rx_trig(rx_trig),
    .rx_clr(rx_fifo_clr), .tx_clr(tx_fifo_clr)
  );

  ureg_line_sts u_lsr (
    .clk(clk), .rst_n(rst_n), .rd_clr(rd_lsr),
    .ev({ev_break, ev_framing, ev_parity, ev_overrun}),
    .rx_ready(rx_ready), .thr_empty(thr_empty), .tx_idle(tx_idle),
    .rx_fifo_err(rx_fifo_err), .lsr(lsr_byte)
  );

  ureg_modem_sts u_msr (
    .clk(clk), .rst_n(rst_n), .rd_clr(rd_msr),
    .pins({dcd, ri, dsr, cts}), .msr(msr_byte)
  );

  always_comb begin
    unique case (ofs)
      OFS_BUF:  bus_rdata = dlab ? div_lo_q : rx_data;
      OFS_IEN:  bus_rdata = dlab ? BYTE_W'(div_hi_q) : BYTE_W'(ien_q);
      OFS_IDF:  bus_rdata = ident_byte(fifo_en, ext_q, int_code);
      OFS_LCTL: bus_rdata = lcr_q;
      OFS_MCTL: bus_rdata = BYTE_W'(mcr_q);
      OFS_LSTS: bus_rdata = lsr_byte;
      OFS_MSTS: bus_rdata = msr_byte;
      default:  bus_rdata = scr_q;
    endcase
  end

  assign div_value = {div_hi_q, div_lo_q};
  assign fifo_ext  = fifo_en & ext_q;
  assign word_len  = lcr_q[1:0];
  assign stop2     = lcr_q[2];
  assign par_en    = lcr_q[3];
  assign par_even  = lcr_q[4];
  assign par_stick = lcr_q[5];
  assign brk_force = lcr_q[6];
  assign irq_en    = ien_q;
  assign {auto_flow, loopback, out2, out1, rts, dtr} = mcr_q;

  AST_DIV_HOLD_NO_DLAB: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dlab) |-> div_value == $past(div_value)); // R3
  AST_IEN_HOLD_DLAB: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dlab) |-> irq_en == $past(irq_en)); // R3
endmodule

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, tx_data, rx_data = '0;
  logic tx_push, rx_pop;
  logic [3:0] int_code = 4'h1;
  logic [15:0] div_value;
  logic [1:0] word_len, rx_trig;
  logic stop2, par_en, par_even, par_stick, brk_force;
  logic [3:0] irq_en;
  logic dtr, rts, out1, out2, loopback, auto_flow;
  logic fifo_en, fifo_ext, dma_mode, rx_fifo_clr, tx_fifo_clr;
  logic rx_ready = 0, ev_overrun = 0, ev_parity = 0, ev_framing = 0, ev_break = 0;
  logic thr_empty = 0, tx_idle = 0, rx_fifo_err = 0;
  logic cts = 0, dsr = 0, ri = 0, dcd = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] tx_q[$];
  logic pop_seen;

  always #5 clk = ~clk;

  uart_regfile u_uart_regfile (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit expect_push);
    if (expect_push) tx_q.push_back(d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata; pop_seen = rx_pop;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  // monitor: scoreboard of transmit pushes
  always @(posedge clk) begin
    if (rst_n && tx_push) begin
      checks++;
      if (tx_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected tx_push actual=%h expected=none", tx_data);
      end else begin
        logic [7:0] e;
        e = tx_q.pop_front();
        if (tx_data !== e) begin
          errors++;
          $display("FAIL R2 tx_data actual=%h expected=%h", tx_data, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    // R1 reset state
    chk("R1 div", div_value, 16'h0);
    rd_chk("R1 ident", 3'd2, 8'h01);
    rd_chk("R1 lcr", 3'd3, 8'h00);
    rd_chk("R1 ien", 3'd1, 8'h00);
    rd_chk("R1 mcr", 3'd4, 8'h00);
    // R2 buffers and interrupt enable
    wr(3'd0, 8'hA5, 1);
    wr(3'd0, 8'h3C, 1);
    rx_data = 8'h5A;
    rd(3'd0, v);
    chk("R2 rx read", v, 8'h5A);
    chk("R2 rx_pop", pop_seen, 1'b1);
    wr(3'd1, 8'hFF, 0);
    rd_chk("R2 ien upper zero", 3'd1, 8'h0F);
    chk("R2 irq_en", irq_en, 4'hF);
    // R3 divisor overlay
    wr(3'd3, 8'h83, 0);
    wr(3'd0, 8'h34, 0);
    wr(3'd1, 8'h12, 0);
    chk("R3 div", div_value, 16'h1234);
    rd(3'd0, v);
    chk("R3 dll read", v, 8'h34);
    chk("R3 no rx_pop", pop_seen, 1'b0);
    rd_chk("R3 dlm read", 3'd1, 8'h12);
    chk("R3 ien kept", irq_en, 4'hF);
    // R4 R5 R6 R7 FIFO control with divisor bit set
    wr(3'd2, 8'hE7, 0);
    chk("R5 rx clr pulse", rx_fifo_clr, 1'b1);
    chk("R5 tx clr pulse", tx_fifo_clr, 1'b1);
    chk("R4 fifo_en", fifo_en, 1'b1);
    chk("R4 trig", rx_trig, 2'b11);
    idle();
    chk("R5 rx clr ends", rx_fifo_clr, 1'b0);
    chk("R5 tx clr ends", tx_fifo_clr, 1'b0);
    rd_chk("R7 ident 64", 3'd2, 8'hE1);
    chk("R6 fifo_ext", fifo_ext, 1'b1);
    wr(3'd3, 8'h03, 0);
    chk("R3 div kept", div_value, 16'h1234);
    wr(3'd2, 8'h01, 0);
    rd_chk("R6 ext retained", 3'd2, 8'hE1);
    int_code = 4'hC;
    wr(3'd2, 8'h00, 0);
    rd_chk("R7 fifo off", 3'd2, 8'h0C);
    int_code = 4'h1;
    wr(3'd3, 8'h80, 0);
    wr(3'd2, 8'h09, 0);
    rd_chk("R6 ext cleared 16", 3'd2, 8'hC1);
    chk("R4 dma", dma_mode, 1'b1);
    // R8 line control
    wr(3'd3, 8'h7E, 0);
    rd_chk("R8 lcr read", 3'd3, 8'h7E);
    chk("R8 fields", {brk_force, par_stick, par_even, par_en, stop2, word_len}, 7'b1111110);
    // R9 modem control
    wr(3'd4, 8'hFF, 0);
    rd_chk("R9 mcr read", 3'd4, 8'h3F);
    chk("R9 pins", {auto_flow, loopback, out2, out1, rts, dtr}, 6'h3F);
    // R10 line status
    thr_empty = 1; rx_ready = 1;
    ev_overrun = 1; idle(); ev_overrun = 0;
    rd_chk("R10 overrun", 3'd5, 8'h23);
    ev_parity = 1;
    rd_chk("R10 read with event", 3'd5, 8'h21);
    ev_parity = 0;
    rd_chk("R10 event kept", 3'd5, 8'h25);
    rd_chk("R10 cleared", 3'd5, 8'h21);
    // R11 modem status
    cts = 1; idle();
    rd_chk("R11 dcts", 3'd6, 8'h11);
    rd_chk("R11 cleared", 3'd6, 8'h10);
    ri = 1; idle();
    rd_chk("R11 ri rise no teri", 3'd6, 8'h50);
    ri = 0; idle();
    rd_chk("R11 teri", 3'd6, 8'h14);
    // R12 scratch
    wr(3'd7, 8'h99, 0);
    rd_chk("R12 scratch", 3'd7, 8'h99);
    chk("R2 tx queue drained", tx_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule